// File: doc/BRIEF.md
# Real-Mode Effective Address Generator

This block sits in the address stage of a 16-bit-compatible processor core. For each memory operand it takes the operand description from the decoder: an addressing mode, base and index register selects, a displacement with its size, and an optional segment override. It also takes the current values of the four address-capable general registers and the four segment registers. From these it forms the 16-bit effective offset, picks the segment, and produces the 20-bit physical address. Reading the register file and performing the memory access are left to the surrounding logic.

The block is a two-stage pipeline and accepts one request per clock. The first stage registers the effective offset, the chosen segment code and an error flag. The second stage registers the physical address, which is the segment value shifted left by four plus the offset, kept within a 1 MB space. If a request names a mode, register or displacement size that the mode does not permit, the block raises the error flag and produces no valid offset or physical address for that request.

Top module: `realAddrUnit`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `offValid`, `errOut` and `physValid` are 0.
- R2: The physical address equals (segment value × 16 + offset) mod 2^20. Two different segment:offset pairs that name the same byte therefore give the same `physOut`.
- R3: A request is presented with `inValid` high. Its `offValid`/`offOut`/`segOut` or `errOut` appear one clock after the accepting edge, and its `physValid`/`physOut` appear one clock after that. One request is taken every cycle. A cycle with `inValid` low produces no valid and no error.
- R4: In direct mode (`mode`=0) the offset is the displacement alone and the default segment is DS. The displacement is zero for size 0, sign-extended from the low 8 bits for size 1, and the full 16 bits for size 2.
- R5: In register-indirect mode (`mode`=1) the offset is the register named by `baseSel`, which may be BX=0, BP=1, SI=2 or DI=3. The displacement fields and `idxSel` are ignored. The default segment is SS for BP and DS otherwise.
- R6: In based mode (`mode`=2) `baseSel` must be BX or BP, and the offset is that register plus the displacement, with an 8-bit displacement sign-extended. The default segment is SS for BP and DS for BX.
- R7: In indexed mode (`mode`=3) `idxSel` must be SI or DI. The offset is that register plus the displacement, and the default segment is DS.
- R8: In based-indexed mode (`mode`=4) `baseSel` must be BX or BP and `idxSel` must be SI or DI. The offset is base + index + displacement, and every offset sum wraps modulo 2^16. The default segment is SS when the base is BP and DS otherwise.
- R9: When `ovrValid` is high, `ovrSeg` replaces the default segment in every mode. Segment codes are ES=0, CS=1, SS=2 and DS=3, and `segOut` reports the code used.
- R10: An accepted request raises `errOut` and produces neither `offValid` nor, a cycle later, `physValid` if any of these holds: `mode` is 5–7; `dispSize` is 3 in direct, based, indexed or based-indexed mode; or a select used by the mode is not permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code |
| baseSel | input | 2 | Base / address register select |
| idxSel | input | 2 | Index register select |
| dispSize | input | 2 | Displacement size: 0 none, 1 byte, 2 word |
| dispIn | input | 16 | Displacement field |
| ovrValid | input | 1 | Segment override present |
| ovrSeg | input | 2 | Override segment code |
| regBx | input | 16 | BX value |
| regBp | input | 16 | BP value |
| regSi | input | 16 | SI value |
| regDi | input | 16 | DI value |
| segEs | input | 16 | ES value |
| segCs | input | 16 | CS value |
| segSs | input | 16 | SS value |
| segDs | input | 16 | DS value |
| offValid | output | 1 | Stage-1 result valid |
| offOut | output | 16 | Effective offset |
| segOut | output | 2 | Segment code used |
| errOut | output | 1 | Illegal request flag |
| physValid | output | 1 | Stage-2 result valid |
| physOut | output | 20 | Physical address |

## Verification
The bench targets the wrap points. One case is a base plus index plus displacement sum that passes 0xFFFF, where a design that keeps the carry would give a wrong offset. Another is a segment near 0xFFFF plus an offset that crosses the 1 MB top, where a design without 20-bit truncation would drop the high bits wrongly. A third is an 8-bit displacement with its top bit set; zero-extending it instead of sign-extending would move the operand forward by 256 bytes. The bench also covers BP-based requests with and without an override: a wrong default or an ignored override shows up as a wrong `segOut` and a wrong physical address. Illegal selects for each restricted mode are checked too, since a design that lets them through would assert a valid with an address built from a register the mode does not allow.

// File: rtl/realAddrPkg.sv
package realAddrPkg;

  localparam int OFF_W         = 16;
  localparam int SEG_W         = 16;
  localparam int SEG_SHIFT     = 4;
  localparam int PHYS_W        = SEG_W + SEG_SHIFT;
  localparam int DISP_NARROW_W = 8;
  localparam int SEL_W         = 2;
  localparam int MODE_W        = 3;

  typedef enum logic [MODE_W-1:0] {
    AM_DIRECT   = 3'd0,
    AM_INDIRECT = 3'd1,
    AM_BASED    = 3'd2,
    AM_INDEXED  = 3'd3,
    AM_BASEIDX  = 3'd4
  } addrMode_e;

  typedef enum logic [SEL_W-1:0] {
    RS_BX = 2'd0,
    RS_BP = 2'd1,
    RS_SI = 2'd2,
    RS_DI = 2'd3
  } regSel_e;

  typedef enum logic [SEL_W-1:0] {
    SG_ES = 2'd0,
    SG_CS = 2'd1,
    SG_SS = 2'd2,
    SG_DS = 2'd3
  } segSel_e;

  typedef enum logic [1:0] {
    DZ_NONE = 2'd0,
    DZ_BYTE = 2'd1,
    DZ_WORD = 2'd2,
    DZ_BAD  = 2'd3
  } dispSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             accept;
    logic             reject;
    logic             addBase;
    logic [SEL_W-1:0] baseSel;
    logic             addIdx;
    logic [SEL_W-1:0] idxSel;
    logic [1:0]       dispMode;
    logic [SEL_W-1:0] segCode;
  } addrStrobe_t;

endpackage

// File: rtl/realAddrCtrl.sv
module realAddrCtrl
  import realAddrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [MODE_W-1:0] mode,
  input  logic [SEL_W-1:0]  baseSel,
  input  logic [SEL_W-1:0]  idxSel,
  input  logic [1:0]        dispSize,
  input  logic              ovrValid,
  input  logic [SEL_W-1:0]  ovrSeg,
  output addrStrobe_t       strobe
);

  logic modeOk, baseOk, idxOk, dispOk, legal;
  logic useBase, useIdx, useDisp, bpBase;
  logic [SEL_W-1:0] defSeg;

  function automatic logic isBaseReg(input logic [SEL_W-1:0] s);
    return (s == RS_BX) || (s == RS_BP);
  endfunction

  function automatic logic isIdxReg(input logic [SEL_W-1:0] s);
    return (s == RS_SI) || (s == RS_DI);
  endfunction

  always_comb begin
    modeOk  = 1'b1;
    baseOk  = 1'b1;
    idxOk   = 1'b1;
    useBase = 1'b0;
    useIdx  = 1'b0;
    useDisp = 1'b1;
    case (mode)
      AM_DIRECT: ;
      AM_INDIRECT: begin
        useBase = 1'b1;
        useDisp = 1'b0;
      end
      AM_BASED: begin
        useBase = 1'b1;
        baseOk  = isBaseReg(baseSel);
      end
      AM_INDEXED: begin
        useIdx = 1'b1;
        idxOk  = isIdxReg(idxSel);
      end
      AM_BASEIDX: begin
        useBase = 1'b1;
        useIdx  = 1'b1;
        baseOk  = isBaseReg(baseSel);
        idxOk   = isIdxReg(idxSel);
      end
      default: modeOk = 1'b0;
    endcase
    dispOk = !useDisp || (dispSize != DZ_BAD);
    legal  = modeOk && baseOk && idxOk && dispOk;
    bpBase = useBase && (baseSel == RS_BP);
    defSeg = bpBase ? SG_SS : SG_DS;

    strobe.accept   = inValid && legal;
    strobe.reject   = inValid && !legal;
    strobe.addBase  = useBase;
    strobe.baseSel  = baseSel;
    strobe.addIdx   = useIdx;
    strobe.idxSel   = idxSel;
    strobe.dispMode = useDisp ? dispSize : DZ_NONE;
    strobe.segCode  = ovrValid ? ovrSeg : defSeg;
  end

  // R4: direct addressing without override always lands in DS
  a_r4_direct_ds: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == AM_DIRECT && !ovrValid) |-> strobe.segCode == SG_DS);

  // R7: indexed addressing without override always lands in DS
  a_r7_indexed_ds: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == AM_INDEXED && !ovrValid) |-> strobe.segCode == SG_DS);

  // R10: a request is never both taken and refused
  a_r10_accept_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.accept && strobe.reject));

  // R10: modes above based-indexed never pass
  a_r10_bad_mode: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode > AM_BASEIDX) |-> strobe.reject);

endmodule

// File: rtl/realAddrPath.sv
module realAddrPath
  import realAddrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  addrStrobe_t       strobe,
  input  logic [OFF_W-1:0]  dispIn,
  input  logic [OFF_W-1:0]  regBx,
  input  logic [OFF_W-1:0]  regBp,
  input  logic [OFF_W-1:0]  regSi,
  input  logic [OFF_W-1:0]  regDi,
  input  logic [SEG_W-1:0]  segEs,
  input  logic [SEG_W-1:0]  segCs,
  input  logic [SEG_W-1:0]  segSs,
  input  logic [SEG_W-1:0]  segDs,
  output logic              offValid,
  output logic [OFF_W-1:0]  offOut,
  output logic [SEL_W-1:0]  segOut,
  output logic              errOut,
  output logic              physValid,
  output logic [PHYS_W-1:0] physOut
);

  localparam int NREG = 1 << SEL_W;

  logic [OFF_W-1:0]  gprArr [NREG];
  logic [SEG_W-1:0]  segArr [NREG];
  logic [OFF_W-1:0]  baseTerm, idxTerm, dispTerm, offNext;
  logic [SEG_W-1:0]  segValQ;
  logic [PHYS_W-1:0] segBase, offWide;

  assign gprArr[RS_BX] = regBx;
  assign gprArr[RS_BP] = regBp;
  assign gprArr[RS_SI] = regSi;
  assign gprArr[RS_DI] = regDi;
  assign segArr[SG_ES] = segEs;
  assign segArr[SG_CS] = segCs;
  assign segArr[SG_SS] = segSs;
  assign segArr[SG_DS] = segDs;

  always_comb begin
    baseTerm = strobe.addBase ? gprArr[strobe.baseSel] : '0;
    idxTerm  = strobe.addIdx  ? gprArr[strobe.idxSel]  : '0;
    case (strobe.dispMode)
      DZ_BYTE: dispTerm = {{(OFF_W-DISP_NARROW_W){dispIn[DISP_NARROW_W-1]}},
                           dispIn[DISP_NARROW_W-1:0]};
      DZ_WORD: dispTerm = dispIn;
      default: dispTerm = '0;
    endcase
    offNext = baseTerm + idxTerm + dispTerm;
  end

  // Stage 1: offset, segment code and value, error
  always_ff @(posedge clk) begin
    if (!rstN) begin
      offValid <= 1'b0;
      errOut   <= 1'b0;
      offOut   <= '0;
      segOut   <= '0;
      segValQ  <= '0;
    end else begin
      offValid <= strobe.accept;
      errOut   <= strobe.reject;
      if (strobe.accept) begin
        offOut  <= offNext;
        segOut  <= strobe.segCode;
        segValQ <= segArr[strobe.segCode];
      end
    end
  end

  assign segBase = {segValQ, {SEG_SHIFT{1'b0}}};
  assign offWide = {{(PHYS_W-OFF_W){1'b0}}, offOut};

  // Stage 2: physical address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      physValid <= 1'b0;
      physOut   <= '0;
    end else begin
      physValid <= offValid;
      if (offValid) physOut <= segBase + offWide;
    end
  end

  // R3: every offset result moves to stage 2 on the next edge
  a_r3_phys_follows: assert property (@(posedge clk) disable iff (!rstN)
    offValid |=> physValid);

  // R3: no physical result without an offset result one cycle earlier
  a_r3_phys_needs_off: assert property (@(posedge clk) disable iff (!rstN)
    physValid |-> $past(offValid));

  // R2: the low nibble of the address is the low nibble of the offset
  a_r2_low_nibble: assert property (@(posedge clk) disable iff (!rstN)
    physValid |-> physOut[SEG_SHIFT-1:0] == $past(offOut[SEG_SHIFT-1:0]));

  // R10: an error never coincides with a valid offset
  a_r10_err_blocks: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> !offValid);

endmodule

// File: rtl/realAddrUnit.sv
module realAddrUnit
  import realAddrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [2:0]  mode,
  input  logic [1:0]  baseSel,
  input  logic [1:0]  idxSel,
  input  logic [1:0]  dispSize,
  input  logic [15:0] dispIn,
  input  logic        ovrValid,
  input  logic [1:0]  ovrSeg,
  input  logic [15:0] regBx,
  input  logic [15:0] regBp,
  input  logic [15:0] regSi,
  input  logic [15:0] regDi,
  input  logic [15:0] segEs,
  input  logic [15:0] segCs,
  input  logic [15:0] segSs,
  input  logic [15:0] segDs,
  output logic        offValid,
  output logic [15:0] offOut,
  output logic [1:0]  segOut,
  output logic        errOut,
  output logic        physValid,
  output logic [19:0] physOut
);

  addrStrobe_t strobe;

  realAddrCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .mode     (mode),
    .baseSel  (baseSel),
    .idxSel   (idxSel),
    .dispSize (dispSize),
    .ovrValid (ovrValid),
    .ovrSeg   (ovrSeg),
    .strobe   (strobe)
  );

  realAddrPath path_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dispIn    (dispIn),
    .regBx     (regBx),
    .regBp     (regBp),
    .regSi     (regSi),
    .regDi     (regDi),
    .segEs     (segEs),
    .segCs     (segCs),
    .segSs     (segSs),
    .segDs     (segDs),
    .offValid  (offValid),
    .offOut    (offOut),
    .segOut    (segOut),
    .errOut    (errOut),
    .physValid (physValid),
    .physOut   (physOut)
  );

  // R1: nothing valid on the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> (!offValid && !physValid && !errOut));

endmodule

// File: tb/realAddrUnit_tb_top.sv
`timescale 1ns/1ps
module realAddrUnit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  baseSel = '0, idxSel = '0, dispSize = '0, ovrSeg = '0;
  logic [15:0] dispIn = '0;
  logic        ovrValid = 1'b0;
  logic [15:0] gpr [4];
  logic [15:0] sreg [4];
  logic        offValid, errOut, physValid;
  logic [15:0] offOut;
  logic [1:0]  segOut;
  logic [19:0] physOut;

  int nChecks = 0;
  int nFails  = 0;

  // model pipeline: pending request, stage 1, stage 2
  int pV, pE, pOff, pSeg, pPhys;  string pTag;
  int s1V = 0, s1E = 0, s1Off = 0, s1Seg = 0, s1Phys = 0;  string s1Tag = "R1";
  int s2V = 0, s2Phys = 0;  string s2Tag = "R1";

  always #2 clk = ~clk;

  realAddrUnit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .baseSel(baseSel), .idxSel(idxSel), .dispSize(dispSize), .dispIn(dispIn),
    .ovrValid(ovrValid), .ovrSeg(ovrSeg),
    .regBx(gpr[0]), .regBp(gpr[1]), .regSi(gpr[2]), .regDi(gpr[3]),
    .segEs(sreg[0]), .segCs(sreg[1]), .segSs(sreg[2]), .segDs(sreg[3]),
    .offValid(offValid), .offOut(offOut), .segOut(segOut), .errOut(errOut),
    .physValid(physValid), .physOut(physOut)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(s1Tag, "offValid", int'(offValid), s1V);
    chk(s1Tag, "errOut", int'(errOut), s1E);
    if (s1V != 0) begin
      chk(s1Tag, "offOut", int'(offOut), s1Off);
      chk(s1Tag, "segOut", int'(segOut), s1Seg);
    end
    chk(s2Tag, "physValid", int'(physValid), s2V);
    if (s2V != 0) chk(s2Tag, "physOut", int'(physOut), s2Phys);
  endtask

  // behavioural reference for one request
  task automatic modelReq(input int v, input int md, input int bs, input int is,
                          input int ds, input int dp, input int ov, input int os);
    int legal, off, bpUse, dext, seg;
    legal = 1; off = 0; bpUse = 0;
    if (ds == 1) dext = ((dp & 'h80) != 0) ? ((dp & 'hFF) | 'hFF00) : (dp & 'hFF);
    else if (ds == 2) dext = dp & 'hFFFF;
    else dext = 0;
    case (md)
      0: begin legal = (ds != 3); off = dext; end
      1: begin off = int'(gpr[bs]); bpUse = (bs == 1); end
      2: begin legal = (bs <= 1) && (ds != 3); off = int'(gpr[bs]) + dext; bpUse = (bs == 1); end
      3: begin legal = (is >= 2) && (ds != 3); off = int'(gpr[is]) + dext; end
      4: begin
        legal = (bs <= 1) && (is >= 2) && (ds != 3);
        off = int'(gpr[bs]) + int'(gpr[is]) + dext; bpUse = (bs == 1);
      end
      default: legal = 0;
    endcase
    off = off % 65536;
    seg = (ov != 0) ? os : (bpUse ? 2 : 3);
    pV = (v != 0 && legal != 0) ? 1 : 0;
    pE = (v != 0 && legal == 0) ? 1 : 0;
    pOff = off; pSeg = seg;
    pPhys = (int'(sreg[seg]) * 16 + off) % (1 << 20);
  endtask

  // one clock: compare, drive, advance
  task automatic step(input string tag, input int v, input int md, input int bs,
                      input int is, input int ds, input int dp, input int ov, input int os);
    compareAll();
    inValid = v[0]; mode = md[2:0]; baseSel = bs[1:0]; idxSel = is[1:0];
    dispSize = ds[1:0]; dispIn = dp[15:0]; ovrValid = ov[0]; ovrSeg = os[1:0];
    modelReq(v, md, bs, is, ds, dp, ov, os);
    pTag = tag;
    @(posedge clk);
    s2V = s1V; s2Phys = s1Phys; s2Tag = s1Tag;
    s1V = pV; s1E = pE; s1Off = pOff; s1Seg = pSeg; s1Phys = pPhys; s1Tag = pTag;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    gpr[0] = 16'h0010; gpr[1] = 16'hFFF0; gpr[2] = 16'h0100; gpr[3] = 16'h0020;
    sreg[0] = 16'h2000; sreg[1] = 16'h3000; sreg[2] = 16'h4000; sreg[3] = 16'h1000;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "offValid in reset", int'(offValid), 0);
    chk("R1", "physValid in reset", int'(physValid), 0);
    chk("R1", "errOut in reset", int'(errOut), 0);
    rstN = 1'b1;
    idle("R1");
    // R4: direct, word / byte / none displacement
    step("R4", 1, 0, 3, 0, 2, 'h1234, 0, 0);
    step("R4", 1, 0, 0, 0, 1, 'h00F0, 0, 0);
    step("R4", 1, 0, 0, 0, 0, 'hABCD, 0, 0);
    // R5: indirect through all four registers, displacement ignored
    step("R5", 1, 1, 0, 1, 3, 'h5555, 0, 0);
    step("R5", 1, 1, 1, 0, 2, 'h5555, 0, 0);
    step("R5", 1, 1, 2, 0, 0, 0, 0, 0);
    step("R5", 1, 1, 3, 0, 1, 'h7F, 0, 0);
    // R6: based, negative byte displacement, BP selects SS
    step("R6", 1, 2, 0, 0, 1, 'h00F0, 0, 0);
    step("R6", 1, 2, 1, 0, 2, 'h0004, 0, 0);
    // R7: indexed
    step("R7", 1, 3, 0, 2, 1, 'h0005, 0, 0);
    step("R7", 1, 3, 1, 3, 2, 'h1000, 0, 0);
    // R8: based-indexed with 16-bit wrap
    step("R8", 1, 4, 1, 3, 0, 0, 0, 0);
    step("R8", 1, 4, 0, 2, 2, 'hFF00, 0, 0);
    // R9: override in several modes
    step("R9", 1, 2, 1, 0, 1, 'h02, 1, 0);
    step("R9", 1, 0, 0, 0, 2, 'h0040, 1, 1);
    step("R9", 1, 4, 0, 3, 0, 0, 1, 2);
    // R10: illegal requests
    step("R10", 1, 2, 2, 0, 1, 1, 0, 0);
    step("R10", 1, 3, 0, 0, 1, 1, 0, 0);
    step("R10", 1, 4, 1, 1, 0, 0, 0, 0);
    step("R10", 1, 7, 0, 2, 0, 0, 0, 0);
    step("R10", 1, 0, 0, 0, 3, 0, 0, 0);
    // R3: gap cycles
    idle("R3");
    idle("R3");
    // R2: 20-bit wrap at top of memory, then overlapping pairs
    sreg[3] = 16'hFFFF;
    step("R2", 1, 0, 0, 0, 2, 'h0020, 0, 0);
    sreg[3] = 16'h1000;
    step("R2", 1, 0, 0, 0, 2, 'h0010, 0, 0);
    sreg[3] = 16'h1001;
    step("R2", 1, 0, 0, 0, 0, 0, 0, 0);
    // R3: back-to-back random traffic
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 4) == 0) begin
        for (int k = 0; k < 4; k++) begin
          gpr[k] = 16'($urandom);
          sreg[k] = 16'($urandom);
        end
      end
      step("R3", int'($urandom % 5 != 0), int'($urandom % 8), int'($urandom % 4),
           int'($urandom % 4), int'($urandom % 4), int'($urandom % 65536),
           int'($urandom % 2), int'($urandom % 4));
    end
    idle("R3");
    idle("R3");
    compareAll();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule